// File: doc/BRIEF.md
# 16-bit Two-Format Processor Core

This block is a single-cycle 16-bit processor core. Every clock cycle it takes one instruction word from an external instruction memory and one data word from an external data memory. It then updates its address register, its data register and its program counter. Instruction bit 15 picks one of two formats. When bit 15 is 0, the word is a constant that goes into the address register. When bit 15 is 1, the word is a compute instruction with three parts: an ALU operation, a set of destinations and a jump condition.

The ALU takes the data register as its first operand. Its second operand is either the address register or the word read from memory. Six control bits shape the operation: each operand can be cleared and inverted, the function is add or AND, and the result can be inverted. The result can be written to any mix of the address register, the data register and memory. It also produces zero and negative flags, and those flags decide whether the program counter loads the address register or steps by one. The low 15 bits of the address register form the data-memory address. The program counter addresses instruction memory.

Top module: `cpu16_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, the address register and the data register to 0.
- R2: When instruction bit 15 is 0, the whole 16-bit word is loaded into the address register. No memory write takes place and the data register keeps its value.
- R3: ALU control bits are instr[11:6] = {zero-x, negate-x, zero-y, negate-y, fsel, negate-out}. They are applied in this order: clear x, invert x, clear y, invert y, then x+y if fsel=1 or x&y if fsel=0, then invert the result. Here x is the data register.
- R4: In a compute instruction, instr[12]=0 makes y the address register and instr[12]=1 makes y the memory read word.
- R5: In a compute instruction, the ALU result goes to each selected destination: instr[5] writes the address register, instr[4] writes the data register, and instr[3] sets `wr_en`. `wr_data` carries the ALU result in that same cycle.
- R6: `wr_en` is instr[15] AND instr[3], and `wr_data` is 0 whenever `wr_en` is 0.
- R7: The jump condition is tested only on a compute instruction. The zero flag is set when the result is all zeros, and the negative flag is result bit 15. A jump is taken when instr[2] is set with the negative flag, when instr[1] is set with the zero flag, or when instr[0] is set with neither flag.
- R8: When a jump is taken, the program counter loads the low 15 bits of the address register as it was before the edge. Otherwise it adds 1 and wraps from 0x7FFF to 0.
- R9: `addr` always equals the low 15 bits of the address register.
- R10: Instruction bits 14 and 13 of a compute instruction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word for the current cycle |
| rd_data | input | 16 | Word read from data memory at `addr` |
| wr_data | output | 16 | ALU result when writing to memory, else 0 |
| wr_en | output | 1 | Data memory write enable |
| addr | output | 15 | Data memory address (low bits of address register) |
| pc | output | 15 | Program counter, the next instruction address |

## Verification
`wr_en`, `wr_data` and the ALU result are combinational from the current instruction and the register contents. They are due in the same cycle the instruction is presented, so the bench drives each instruction just after a falling edge and samples them 1 ns later, before the next rising edge. The address register, the data register and the program counter change on the rising edge that follows, so `addr` and `pc` are checked at the next falling edge. The data register has no port of its own. The bench reads it through a following compute instruction that passes x through the ALU to memory. It checks the result on `wr_data` in that instruction's own cycle.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
    localparam int WORD_W = 16;
    localparam int PC_W   = 15;
    localparam int JMP_W  = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PC_W-1:0]   paddr_t;

    typedef enum logic {
        KIND_CONST = 1'b0,
        KIND_COMP  = 1'b1
    } kind_e;

    typedef struct packed {
        logic clr_x;
        logic inv_x;
        logic clr_y;
        logic inv_y;
        logic fsel;
        logic inv_o;
    } alu_ctl_t;

    typedef struct packed {
        kind_e            kind;
        logic             y_from_mem;
        alu_ctl_t         alu;
        logic             ld_a;
        logic             ld_d;
        logic             st_m;
        logic [JMP_W-1:0] jcond;
    } dec_t;

    typedef struct packed {
        word_t  a;
        word_t  d;
        paddr_t pc;
    } core_state_t;
endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
    import cpu16_pkg::*;
(
    input  word_t instr,
    output dec_t  dec
);
    logic unused_fmt_bits;
    assign unused_fmt_bits = ^instr[14:13];

    always_comb begin
        dec            = '0;
        dec.kind       = instr[15] ? KIND_COMP : KIND_CONST;
        dec.y_from_mem = instr[12];
        dec.alu        = alu_ctl_t'(instr[11:6]);
        if (dec.kind == KIND_COMP) begin
            dec.ld_a  = instr[5];
            dec.ld_d  = instr[4];
            dec.st_m  = instr[3];
            dec.jcond = instr[2:0];
        end else begin
            dec.ld_a  = 1'b1;
        end
    end
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  alu_ctl_t     ctl,
    output logic [W-1:0] res,
    output logic         zr,
    output logic         ng
);
    logic [W-1:0] x_c, x_n, y_c, y_n, f_out;

    always_comb begin
        x_c   = ctl.clr_x ? '0 : x;
        x_n   = ctl.inv_x ? ~x_c : x_c;
        y_c   = ctl.clr_y ? '0 : y;
        y_n   = ctl.inv_y ? ~y_c : y_c;
        f_out = ctl.fsel ? (x_n + y_n) : (x_n & y_n);
        res   = ctl.inv_o ? ~f_out : f_out;
        zr    = (res == '0);
        ng    = res[W-1];
    end
endmodule

// File: rtl/cpu16_branch.sv
module cpu16_branch
    import cpu16_pkg::*;
(
    input  logic [JMP_W-1:0] jcond,
    input  logic             zr,
    input  logic             ng,
    output logic             take
);
    logic hit_neg, hit_zero, hit_pos;

    always_comb begin
        hit_neg  = jcond[2] & ng;
        hit_zero = jcond[1] & zr;
        hit_pos  = jcond[0] & ~zr & ~ng;
        take     = hit_neg | hit_zero | hit_pos;
    end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] instr,
    input  logic [15:0] rd_data,
    output logic [15:0] wr_data,
    output logic        wr_en,
    output logic [14:0] addr,
    output logic [14:0] pc
);
    dec_t        dec;
    core_state_t st_d, st_q;
    word_t       alu_y, alu_res;
    logic        alu_zr, alu_ng, jmp_take;

    cpu16_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    assign alu_y = dec.y_from_mem ? rd_data : st_q.a;

    cpu16_alu #(.W(WORD_W)) u_alu (
        .x   (st_q.d),
        .y   (alu_y),
        .ctl (dec.alu),
        .res (alu_res),
        .zr  (alu_zr),
        .ng  (alu_ng)
    );

    cpu16_branch u_branch (
        .jcond (dec.jcond),
        .zr    (alu_zr),
        .ng    (alu_ng),
        .take  (jmp_take)
    );

    always_comb begin
        st_d = st_q;
        if (dec.ld_a) begin
            st_d.a = (dec.kind == KIND_CONST) ? instr : alu_res;
        end
        if (dec.ld_d) begin
            st_d.d = alu_res;
        end
        st_d.pc = jmp_take ? st_q.a[PC_W-1:0] : st_q.pc + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = dec.st_m;
    assign wr_data = dec.st_m ? alu_res : '0;
    assign addr    = st_q.a[PC_W-1:0];
    assign pc      = st_q.pc;

    // Checks on register behaviour over time
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && addr == '0))
        else $error("R1: state not cleared by reset");

    assert_const_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!instr[15]) |=> (st_q.a == $past(instr)))
        else $error("R2: constant not loaded into A");

    assert_d_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(instr[15] && instr[4]) |=> $stable(st_q.d))
        else $error("R5: D changed without a D destination");

    assert_wdata_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_data != '0) |-> wr_en)
        else $error("R6: write data driven without write enable");

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        alu_zr |-> !alu_ng)
        else $error("R7: zero and negative flags both set");

    assert_pc_jump_R8: assert property (@(posedge clk) disable iff (rst)
        jmp_take |=> (pc == $past(addr)))
        else $error("R8: taken jump did not load A");

    assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
        !jmp_take |=> (pc == PC_W'($past(pc) + PC_W'(1))))
        else $error("R8: program counter did not step by one");
endmodule

// File: tb/cpu16_core_tb.sv
`timescale 1ns/1ps
module cpu16_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = 16'h0000;
    logic [15:0] rd_data = 16'h0000;
    logic [15:0] wr_data;
    logic        wr_en;
    logic [14:0] addr;
    logic [14:0] pc;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // ALU codes: {clr_x, inv_x, clr_y, inv_y, fsel, inv_o}
    localparam logic [5:0] OP_ZERO = 6'b101010;
    localparam logic [5:0] OP_ONE  = 6'b111111;
    localparam logic [5:0] OP_NEG1 = 6'b111010;
    localparam logic [5:0] OP_X    = 6'b001100;
    localparam logic [5:0] OP_Y    = 6'b110000;
    localparam logic [5:0] OP_NOTX = 6'b001101;
    localparam logic [5:0] OP_XINC = 6'b011111;
    localparam logic [5:0] OP_ADD  = 6'b000010;
    localparam logic [5:0] OP_AND  = 6'b000000;
    localparam logic [5:0] OP_SUB  = 6'b010011;
    // destinations {A, D, M}
    localparam logic [2:0] TO_M = 3'b001;
    localparam logic [2:0] TO_D = 3'b010;
    localparam logic [2:0] TO_A = 3'b100;

    always #2.5 clk = ~clk;

    cpu16_core u_dut (
        .clk     (clk),
        .rst     (rst),
        .instr   (instr),
        .rd_data (rd_data),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .addr    (addr),
        .pc      (pc)
    );

    function automatic logic [15:0] comp(input logic m, input logic [5:0] op,
                                         input logic [2:0] dst, input logic [2:0] j);
        return {3'b111, m, op, dst, j};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] w, input logic [15:0] rd);
        instr   = w;
        rd_data = rd;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input logic [15:0] w);
        put(w, 16'h0000);
        tick();
    endtask

    // x passes through the ALU to memory: reveals D
    task automatic chk_d(input string req, input logic [15:0] exp);
        put(comp(1'b0, OP_X, TO_M, 3'b000), 16'h0000);
        chk({req, " wr_en"}, {15'd0, wr_en}, 16'h0001);
        chk({req, " D"}, wr_data, exp);
        tick();
    endtask

    task automatic t_reset();
        chk("R1 pc after reset", {1'b0, pc}, 16'h0000);
        chk("R1 A after reset", {1'b0, addr}, 16'h0000);
        chk_d("R1", 16'h0000);
    endtask

    task automatic t_const();
        logic [14:0] p0;
        p0 = pc;
        put(16'h1234, 16'hBEEF);
        chk("R6 wr_en on constant", {15'd0, wr_en}, 16'h0000);
        chk("R6 wr_data on constant", wr_data, 16'h0000);
        tick();
        chk("R2 A loaded / R9 addr", {1'b0, addr}, 16'h1234);
        chk("R8 pc step", {1'b0, pc}, {1'b0, p0 + 15'd1});
        chk_d("R2 D kept", 16'h0000);
    endtask

    task automatic t_alu();
        logic [5:0]  ops  [10] = '{OP_ADD, OP_AND, OP_SUB, OP_NEG1, OP_ONE,
                                   OP_ZERO, OP_NOTX, OP_XINC, OP_X, OP_Y};
        logic [15:0] exps [10] = '{16'h0008, 16'h0001, 16'h0002, 16'hFFFF, 16'h0001,
                                   16'h0000, 16'hFFFA, 16'h0006, 16'h0005, 16'h0003};
        run(16'h0005);
        run(comp(1'b0, OP_Y, TO_D, 3'b000));
        run(16'h0003);
        for (int i = 0; i < 10; i++) begin
            put(comp(1'b0, ops[i], TO_M, 3'b000), 16'h0000);
            chk($sformatf("R3 op %b", ops[i]), wr_data, exps[i]);
            tick();
        end
    endtask

    task automatic t_operand();
        put(comp(1'b1, OP_ADD, TO_M, 3'b000), 16'h0007);
        chk("R4 D+mem", wr_data, 16'h000C);
        tick();
        put(comp(1'b1, OP_Y, TO_M, 3'b000), 16'h0007);
        chk("R4 y=mem", wr_data, 16'h0007);
        tick();
        put(comp(1'b0, OP_Y, TO_M, 3'b000), 16'h0007);
        chk("R4 y=A", wr_data, 16'h0003);
        tick();
    endtask

    task automatic t_dest();
        put(comp(1'b0, OP_XINC, TO_A | TO_D, 3'b000), 16'h0000);
        chk("R5 no write enable", {15'd0, wr_en}, 16'h0000);
        tick();
        chk("R5 A from ALU", {1'b0, addr}, 16'h0006);
        chk_d("R5 D from ALU", 16'h0006);
        run(comp(1'b0, OP_ONE, TO_M, 3'b000));
        chk_d("R5 D kept without dest", 16'h0006);
    endtask

    task automatic t_ignored();
        put({3'b100, 1'b0, OP_X, TO_M, 3'b000}, 16'h0000);
        chk("R10 write with bits14:13=00", wr_data, 16'h0006);
        tick();
        run({3'b101, 1'b0, OP_ONE, TO_A, 3'b000});
        chk("R10 A with bits14:13=01", {1'b0, addr}, 16'h0001);
    endtask

    task automatic jtry(input string req, input logic [15:0] w, input logic taken);
        logic [14:0] p0, a0;
        p0 = pc;
        a0 = addr;
        run(w);
        chk(req, {1'b0, pc}, taken ? {1'b0, a0} : {1'b0, p0 + 15'd1});
    endtask

    task automatic t_jump();
        run(16'h0020);
        run(comp(1'b0, OP_ZERO, TO_D, 3'b000));
        jtry("R7 zero JEQ taken",     comp(1'b0, OP_X, 3'b000, 3'b010), 1'b1);
        jtry("R7 zero JLT not taken", comp(1'b0, OP_X, 3'b000, 3'b100), 1'b0);
        jtry("R7 zero JGT not taken", comp(1'b0, OP_X, 3'b000, 3'b001), 1'b0);
        run(comp(1'b0, OP_NEG1, TO_D, 3'b000));
        jtry("R7 neg JLT taken",      comp(1'b0, OP_X, 3'b000, 3'b100), 1'b1);
        jtry("R7 neg JEQ not taken",  comp(1'b0, OP_X, 3'b000, 3'b010), 1'b0);
        jtry("R7 neg JGT not taken",  comp(1'b0, OP_X, 3'b000, 3'b001), 1'b0);
        run(comp(1'b0, OP_ONE, TO_D, 3'b000));
        jtry("R7 pos JGT taken",      comp(1'b0, OP_X, 3'b000, 3'b001), 1'b1);
        jtry("R7 pos JLE not taken",  comp(1'b0, OP_X, 3'b000, 3'b110), 1'b0);
        jtry("R7 always taken",       comp(1'b0, OP_ZERO, 3'b000, 3'b111), 1'b1);
        jtry("R7 constant never jumps", 16'h0007, 1'b0);
    endtask

    task automatic t_wrap();
        run(comp(1'b0, OP_NEG1, TO_A, 3'b000));
        chk("R9 addr low 15 bits", {1'b0, addr}, 16'h7FFF);
        run(comp(1'b0, OP_ZERO, 3'b000, 3'b111));
        chk("R8 jump to low 15 bits", {1'b0, pc}, 16'h7FFF);
        run(comp(1'b0, OP_ZERO, 3'b000, 3'b000));
        chk("R8 pc wraps", {1'b0, pc}, 16'h0000);
    endtask

    task automatic t_midreset();
        run(16'h0ABC);
        run(comp(1'b0, OP_ONE, TO_D, 3'b000));
        rst = 1'b1;
        run(16'h0000);
        rst = 1'b0;
        chk("R1 pc cleared", {1'b0, pc}, 16'h0000);
        chk("R1 A cleared", {1'b0, addr}, 16'h0000);
        chk_d("R1 D cleared", 16'h0000);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 5000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_const();
        t_alu();
        t_operand();
        t_dest();
        t_ignored();
        t_jump();
        t_wrap();
        t_midreset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule